// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches a running real-time calendar and raises an alarm when the calendar reaches a programmed moment. Five calendar fields (seconds, minutes, hours, day-of-week and date) each have a matching alarm value and their own enable bit. A field takes part in the comparison only when its enable is set. The alarm fires when every enabled field equals its alarm value in the same cycle. It never fires when no field is enabled.

A match sets a sticky alarm flag, and the flag drives a pending-interrupt line. The flag stays set until software pulses a clear strobe. Taking the interrupt does not clear it, and turning the interrupt enable off does not clear it either. The outgoing interrupt request is the pending line gated by the interrupt enable. The flag sets only in the first cycle of a match, so a clear issued while the calendar still matches does not bring the flag straight back.

A small helper alongside the comparator reports how many days February has for a two-digit year register.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the alarm flag, the pending line and the interrupt request are all 0.
- R2: When all five fields are enabled and each equals its alarm value, the flag reads 1 on the clock edge after the match begins. The enable bit order is bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day-of-week, bit 4 date.
- R3: A field whose enable bit is 0 has no effect: the alarm fires when only the enabled fields match, whatever the disabled fields hold.
- R4: If any enabled field differs from its alarm value, the flag is not set.
- R5: With the enable vector all zero, the flag never sets, even if every field equals its alarm value.
- R6: Once set, the flag stays 1 after the match ends and until a clear strobe is given.
- R7: A clear strobe clears the flag on the next edge. If the match continues without a new start, the flag stays 0.
- R8: A clear strobe in the same cycle as the start of a new match leaves the flag at 1.
- R9: The pending line follows the flag regardless of the interrupt enable. The interrupt request is 1 only when the flag is 1 and the interrupt enable is 1.
- R10: The February length output is 29 when the year value is a multiple of four, including 0. Otherwise it is 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 7 | Calendar seconds |
| cur_min | input | 7 | Calendar minutes |
| cur_hour | input | 7 | Calendar hours |
| cur_dow | input | 7 | Calendar day-of-week |
| cur_date | input | 7 | Calendar date |
| alm_sec | input | 7 | Alarm seconds |
| alm_min | input | 7 | Alarm minutes |
| alm_hour | input | 7 | Alarm hours |
| alm_dow | input | 7 | Alarm day-of-week |
| alm_date | input | 7 | Alarm date |
| field_en | input | 5 | Per-field enable (bit 0 sec ... bit 4 date) |
| flag_clr | input | 1 | Software flag-clear strobe |
| irq_en | input | 1 | Interrupt enable |
| year | input | 7 | Two-digit year register |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pending | output | 1 | Pending-interrupt line |
| irq_req | output | 1 | Gated interrupt request |
| feb_days | output | 5 | Last day of February (28 or 29) |

## Verification
Two functions can act in the same cycle: setting the flag on the start of a match, and clearing it on the software strobe. The bench first breaks any match by disabling all fields. It then applies a matching pattern and raises the clear strobe in that same cycle, and expects the flag to read 1 after the edge. It also holds a match steady across a clear strobe and expects the flag to read 0 after the edge and to stay 0 while the match continues.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int DAYS_W     = 5;

  // Index of each calendar field in the enable vector.
  typedef enum int {
    F_SEC  = 0,
    F_MIN  = 1,
    F_HOUR = 2,
    F_DOW  = 3,
    F_DATE = 4
  } field_idx_e;

  // Last day of February for a two-digit year: leap when divisible by four.
  function automatic logic [DAYS_W-1:0] feb_last_day(input logic [1:0] year_low);
    return (year_low == 2'b00) ? DAYS_W'(29) : DAYS_W'(28);
  endfunction
endpackage

// File: rtl/cal_field_cmp.sv
module cal_field_cmp #(
  parameter int FIELD_W = 7
) (
  input  logic [FIELD_W-1:0] cur_val,
  input  logic [FIELD_W-1:0] alm_val,
  input  logic               enable,
  output logic               field_ok
);
  logic equal;
  assign equal    = (cur_val == alm_val);
  // A field that is not enabled never blocks the overall match.
  assign field_ok = !enable || equal;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match_all,
  input  logic clr,
  output logic flag,
  output logic match_rise
);
  logic match_q;

  assign match_rise = match_all && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      match_q <= match_all;
      if (match_rise)
        flag <= 1'b1;          // a set wins over a clear in the same cycle
      else if (clr)
        flag <= 1'b0;
    end
  end

  a_r2_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    match_rise |=> flag);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match_rise) |=> !flag);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && match_rise) |=> flag);
endmodule

// File: rtl/cal_feb_len.sv
module cal_feb_len
  import cal_alarm_pkg::*;
#(
  parameter int YEAR_W = 7
) (
  input  logic [YEAR_W-1:0] year,
  output logic [DAYS_W-1:0] feb_days
);
  assign feb_days = feb_last_day(year[1:0]);

  always_comb begin
    a_r10_range: assert (feb_days == DAYS_W'(28) || feb_days == DAYS_W'(29));
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int FIELD_W = 7,
  parameter int YEAR_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FIELD_W-1:0]    cur_sec,
  input  logic [FIELD_W-1:0]    cur_min,
  input  logic [FIELD_W-1:0]    cur_hour,
  input  logic [FIELD_W-1:0]    cur_dow,
  input  logic [FIELD_W-1:0]    cur_date,
  input  logic [FIELD_W-1:0]    alm_sec,
  input  logic [FIELD_W-1:0]    alm_min,
  input  logic [FIELD_W-1:0]    alm_hour,
  input  logic [FIELD_W-1:0]    alm_dow,
  input  logic [FIELD_W-1:0]    alm_date,
  input  logic [NUM_FIELDS-1:0] field_en,
  input  logic                  flag_clr,
  input  logic                  irq_en,
  input  logic [YEAR_W-1:0]     year,
  output logic                  alarm_flag,
  output logic                  irq_pending,
  output logic                  irq_req,
  output logic [DAYS_W-1:0]     feb_days
);
  logic [FIELD_W-1:0]    cur_f [NUM_FIELDS];
  logic [FIELD_W-1:0]    alm_f [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] field_ok;
  logic                  match_all;
  logic                  match_rise;

  assign cur_f[F_SEC]  = cur_sec;
  assign cur_f[F_MIN]  = cur_min;
  assign cur_f[F_HOUR] = cur_hour;
  assign cur_f[F_DOW]  = cur_dow;
  assign cur_f[F_DATE] = cur_date;
  assign alm_f[F_SEC]  = alm_sec;
  assign alm_f[F_MIN]  = alm_min;
  assign alm_f[F_HOUR] = alm_hour;
  assign alm_f[F_DOW]  = alm_dow;
  assign alm_f[F_DATE] = alm_date;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    cal_field_cmp #(.FIELD_W(FIELD_W)) u_cmp (
      .cur_val (cur_f[i]),
      .alm_val (alm_f[i]),
      .enable  (field_en[i]),
      .field_ok(field_ok[i])
    );
  end

  // At least one field must take part, or nothing ever matches.
  assign match_all = (|field_en) && (&field_ok);

  cal_alarm_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_all (match_all),
    .clr       (flag_clr),
    .flag      (alarm_flag),
    .match_rise(match_rise)
  );

  assign irq_pending = alarm_flag;
  assign irq_req     = irq_pending && irq_en;

  cal_feb_len #(.YEAR_W(YEAR_W)) u_feb (
    .year    (year),
    .feb_days(feb_days)
  );

  a_r5_no_enable_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (field_en == '0 && !alarm_flag) |=> !alarm_flag);
  a_r4_mismatch_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((field_en & ~field_ok) != '0) |-> !match_rise);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!alarm_flag && !irq_req));
endmodule

// File: tb/cal_alarm_match_test.sv
module cal_alarm_match_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_dow = 0, cur_date = 0;
  logic [6:0] alm_sec = 0, alm_min = 0, alm_hour = 0, alm_dow = 0, alm_date = 0;
  logic [4:0] field_en = 0;
  logic       flag_clr = 0, irq_en = 0;
  logic [6:0] year = 0;
  logic       alarm_flag, irq_pending, irq_req;
  logic [4:0] feb_days;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cal_alarm_match uut (
    .clk(clk), .rst_n(rst_n),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_dow(cur_dow), .cur_date(cur_date),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_dow(alm_dow), .alm_date(alm_date),
    .field_en(field_en), .flag_clr(flag_clr), .irq_en(irq_en), .year(year),
    .alarm_flag(alarm_flag), .irq_pending(irq_pending), .irq_req(irq_req),
    .feb_days(feb_days)
  );

  // {expect, en[4:0], cur date,dow,hour,min,sec, alm date,dow,hour,min,sec}
  localparam logic [75:0] VEC [8] = '{
    {1'b1, 5'b11111, 7'd15, 7'd3, 7'd12, 7'd30, 7'd45, 7'd15, 7'd3, 7'd12, 7'd30, 7'd45}, // R2
    {1'b0, 5'b11111, 7'd15, 7'd3, 7'd12, 7'd30, 7'd44, 7'd15, 7'd3, 7'd12, 7'd30, 7'd45}, // R4
    {1'b1, 5'b00001, 7'd1,  7'd2, 7'd3,  7'd4,  7'd59, 7'd9,  7'd6, 7'd7,  7'd8,  7'd59}, // R3
    {1'b1, 5'b10100, 7'd31, 7'd0, 7'd23, 7'd10, 7'd0,  7'd31, 7'd5, 7'd23, 7'd11, 7'd9},  // R3
    {1'b0, 5'b00000, 7'd5,  7'd5, 7'd5,  7'd5,  7'd5,  7'd5,  7'd5, 7'd5,  7'd5,  7'd5},  // R5
    {1'b0, 5'b01000, 7'd5,  7'd1, 7'd5,  7'd5,  7'd5,  7'd5,  7'd2, 7'd5,  7'd5,  7'd5},  // R4
    {1'b1, 5'b10000, 7'd28, 7'd1, 7'd2,  7'd3,  7'd4,  7'd28, 7'd6, 7'd9,  7'd9,  7'd9},  // R3
    {1'b0, 5'b00110, 7'd1,  7'd1, 7'd6,  7'd20, 7'd1,  7'd1,  7'd1, 7'd7,  7'd20, 7'd1}   // R4
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic all_match(input logic [6:0] v);
    {cur_sec, cur_min, cur_hour, cur_dow, cur_date} = {5{v}};
    {alm_sec, alm_min, alm_hour, alm_dow, alm_date} = {5{v}};
  endtask

  task automatic break_and_clear();
    field_en = 0; flag_clr = 1;
    step();
    flag_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    chk("R1 flag", alarm_flag, 0);
    chk("R1 pending", irq_pending, 0);
    chk("R1 irq", irq_req, 0);
    step(); step();
    rst_n = 1;
    step();
    chk("R1 flag after release", alarm_flag, 0);

    for (int i = 0; i < 8; i++) begin
      break_and_clear();
      field_en = VEC[i][74:70];
      {cur_date, cur_dow, cur_hour, cur_min, cur_sec} = VEC[i][69:35];
      {alm_date, alm_dow, alm_hour, alm_min, alm_sec} = VEC[i][34:0];
      step();
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), alarm_flag, int'(VEC[i][75]));
    end

    // R6 and R9: sticky flag, pending and gated request.
    break_and_clear();
    all_match(7'd20); field_en = 5'b11111; irq_en = 1;
    step();
    chk("R2 set", alarm_flag, 1);
    cur_sec = 7'd21;
    step(); step(); step();
    chk("R6 sticky", alarm_flag, 1);
    chk("R9 irq enabled", irq_req, 1);
    irq_en = 0;
    #1;
    chk("R9 pending held", irq_pending, 1);
    chk("R9 irq gated", irq_req, 0);
    step();
    chk("R6 held while disabled", alarm_flag, 1);

    // R7: clear during a continuing match.
    break_and_clear();
    all_match(7'd33); field_en = 5'b00001;
    step();
    chk("R7 pre set", alarm_flag, 1);
    flag_clr = 1;
    step();
    flag_clr = 0;
    chk("R7 cleared", alarm_flag, 0);
    step(); step();
    chk("R7 no re-set", alarm_flag, 0);

    // R8: clear in same cycle as a new match start.
    break_and_clear();
    all_match(7'd7); field_en = 5'b11111; flag_clr = 1;
    step();
    flag_clr = 0;
    chk("R8 set wins", alarm_flag, 1);

    // R5: no enable with steady equality never sets.
    break_and_clear();
    all_match(7'd9);
    step(); step();
    chk("R5 no field", alarm_flag, 0);

    // R10: February length over all two-digit years.
    for (int y = 0; y < 100; y++) begin
      year = 7'(y);
      #1;
      chk($sformatf("R10 year %0d", y), feb_days, ((y / 4) * 4 == y) ? 29 : 28);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule